// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit forms the memory address for a load or store and, for the two self-updating modes, the new value of the base register. Each request carries a base register value, the program counter, an index register value, a full-width immediate (an offset, or a complete address in absolute mode), a three-bit mode code, a two-bit left-shift amount for the index, and a subtract select. The unit has no state of its own beyond its output register. It performs no memory access, alignment checking, exclusive-access tracking or instruction decoding.

Requests enter through a valid/ready handshake. A request is accepted on a rising clock edge when `req_valid` and `req_ready` are both high. Its result appears on the response side one cycle later, on the `rsp_*` pins. The response stays put until `rsp_ready` is seen high with `rsp_valid`. The unit raises `req_ready` whenever its response slot is empty or is being drained in the same cycle, so a stalled consumer stalls the producer directly. The unit never drops or reorders a request.

Mode codes on `req_mode`: 0 absolute, 1 register-indirect, 2 base plus offset, 3 indexed, 4 scaled-indexed, 5 pre-indexed with writeback, 6 post-indexed, 7 PC-relative.

Top module: `lsagu_top`

## Requirements
- R1: Mode 0 (absolute): the address equals `req_imm`, and `req_sub`, base, pc and index have no effect on it.
- R2: Mode 1 (register-indirect): the address equals `req_base`.
- R3: Mode 2 (base plus offset): the address is `req_base + req_imm` when `req_sub`=0 and `req_base - req_imm` when `req_sub`=1.
- R4: Mode 3 (indexed): the address is `req_base` plus or minus `req_index`, as selected by `req_sub`. The shift amount has no effect in this mode.
- R5: Mode 4 (scaled-indexed): the address is `req_base` plus or minus `req_index` shifted left by `req_shift`, for shifts 0 to 3 (factors 1, 2, 4, 8).
- R6: Mode 5 (pre-indexed): the address is `req_base` ± `req_imm`, `rsp_wb_en`=1, and `rsp_wb_val` equals that same address.
- R7: Mode 6 (post-indexed): the address is the unmodified `req_base`, `rsp_wb_en`=1, and `rsp_wb_val` is `req_base` ± `req_imm`.
- R8: Mode 7 (PC-relative): the address is `req_pc` plus or minus `req_imm`.
- R9: In every mode other than 5 and 6, `rsp_wb_en`=0 and `rsp_wb_val` equals `req_base`.
- R10: All sums and differences wrap modulo 2^ADDR_W.
- R11: The response to an accepted request appears with `rsp_valid`=1 on the clock edge after acceptance.
- R12: While `rsp_valid`=1 and `rsp_ready`=0, `req_ready` is 0 and every response output holds its value.
- R13: After reset, `rsp_valid`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request this cycle |
| req_mode | input | 3 | Addressing mode code |
| req_sub | input | 1 | 1 subtracts the offset or index, 0 adds it |
| req_shift | input | SHIFT_W | Left shift applied to the index in scaled mode |
| req_base | input | ADDR_W | Base register value |
| req_pc | input | ADDR_W | Program counter |
| req_index | input | ADDR_W | Index register value |
| req_imm | input | ADDR_W | Immediate offset, or absolute address in mode 0 |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | ADDR_W | Effective address |
| rsp_wb_en | output | 1 | Base register must be written back |
| rsp_wb_val | output | ADDR_W | New base register value |

## Verification
The hardest situation to reach from the ports is a second request waiting while the first response is blocked. The bench must show that the held response does not change and that the waiting request is taken exactly when the block lifts. To get there, the bench holds `rsp_ready` low and issues one request. It then presents a different request, checks that it is refused for a cycle, and releases `rsp_ready`. The arithmetic corners are reached by a full sweep of every mode, direction and shift over operand sets chosen so that both the additions and the subtractions cross the top of the address space.

// File: rtl/lsagu_pkg.sv
package lsagu_pkg;
  typedef enum logic [2:0] {
    AM_ABS   = 3'd0,
    AM_IND   = 3'd1,
    AM_OFS   = 3'd2,
    AM_IDX   = 3'd3,
    AM_SIDX  = 3'd4,
    AM_PRE   = 3'd5,
    AM_POST  = 3'd6,
    AM_PCREL = 3'd7
  } lsagu_mode_e;
endpackage

// File: rtl/lsagu_opnd_sel.sv
module lsagu_opnd_sel
  import lsagu_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SHIFT_W = 2
) (
  input  lsagu_mode_e        mode,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [ADDR_W-1:0]  base,
  input  logic [ADDR_W-1:0]  pc,
  input  logic [ADDR_W-1:0]  index,
  input  logic [ADDR_W-1:0]  imm,
  output logic [ADDR_W-1:0]  lhs,
  output logic [ADDR_W-1:0]  rhs
);
  // Left operand: the program counter only for PC-relative, else the base.
  always_comb begin
    lhs = (mode == AM_PCREL) ? pc : base;
  end

  // Right operand: the index (plain or scaled) or the immediate.
  always_comb begin
    unique case (mode)
      AM_IDX:  rhs = index;
      AM_SIDX: rhs = index << shift;
      default: rhs = imm;
    endcase
  end
endmodule

// File: rtl/lsagu_addsub.sv
module lsagu_addsub #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] a,
  input  logic [ADDR_W-1:0] b,
  input  logic              sub,
  output logic [ADDR_W-1:0] y
);
  // Single adder: subtract is a + ~b + 1, result truncated to ADDR_W bits.
  logic [ADDR_W-1:0] b_eff;
  always_comb begin
    b_eff = sub ? ~b : b;
    y     = a + b_eff + {{(ADDR_W-1){1'b0}}, sub};
  end
endmodule

// File: rtl/lsagu_rsp_reg.sv
module lsagu_rsp_reg #(
  parameter int DATA_W = 65
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic              vld_q;
  logic [DATA_W-1:0] dat_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) dat_q <= in_data;
    end
  end

  // R12
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !out_ready) |=> (vld_q && $stable(dat_q)));

  // R12
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !out_ready) |-> !in_ready);

  // R11
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> vld_q);
endmodule

// File: rtl/lsagu_top.sv
module lsagu_top
  import lsagu_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SHIFT_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [2:0]         req_mode,
  input  logic               req_sub,
  input  logic [SHIFT_W-1:0] req_shift,
  input  logic [ADDR_W-1:0]  req_base,
  input  logic [ADDR_W-1:0]  req_pc,
  input  logic [ADDR_W-1:0]  req_index,
  input  logic [ADDR_W-1:0]  req_imm,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [ADDR_W-1:0]  rsp_addr,
  output logic               rsp_wb_en,
  output logic [ADDR_W-1:0]  rsp_wb_val
);
  localparam int RSP_W = 2 * ADDR_W + 1;

  lsagu_mode_e       mode;
  logic [ADDR_W-1:0] lhs, rhs, sum;
  logic [ADDR_W-1:0] ea_c, wbv_c;
  logic              wb_c;
  logic [RSP_W-1:0]  rsp_pack;

  assign mode = lsagu_mode_e'(req_mode);

  lsagu_opnd_sel #(.ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W)) u_sel (
    .mode (mode),
    .shift(req_shift),
    .base (req_base),
    .pc   (req_pc),
    .index(req_index),
    .imm  (req_imm),
    .lhs  (lhs),
    .rhs  (rhs)
  );

  lsagu_addsub #(.ADDR_W(ADDR_W)) u_add (
    .a  (lhs),
    .b  (rhs),
    .sub(req_sub),
    .y  (sum)
  );

  always_comb begin
    wb_c  = (mode == AM_PRE) || (mode == AM_POST);
    wbv_c = wb_c ? sum : req_base;
    unique case (mode)
      AM_ABS:            ea_c = req_imm;
      AM_IND, AM_POST:   ea_c = req_base;
      default:           ea_c = sum;
    endcase
  end

  lsagu_rsp_reg #(.DATA_W(RSP_W)) u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid),
    .in_ready (req_ready),
    .in_data  ({ea_c, wb_c, wbv_c}),
    .out_valid(rsp_valid),
    .out_ready(rsp_ready),
    .out_data (rsp_pack)
  );

  assign rsp_addr   = rsp_pack[RSP_W-1 -: ADDR_W];
  assign rsp_wb_en  = rsp_pack[ADDR_W];
  assign rsp_wb_val = rsp_pack[ADDR_W-1:0];

  // R1
  abs_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mode == 3'd0) |=> (rsp_addr == $past(req_imm)));

  // R6
  pre_same_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mode == 3'd5) |=> (rsp_wb_en && rsp_wb_val == rsp_addr));

  // R7
  post_old_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mode == 3'd6) |=> (rsp_wb_en && rsp_addr == $past(req_base)));

  // R9
  no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mode != 3'd5 && req_mode != 3'd6)
      |=> (!rsp_wb_en && rsp_wb_val == $past(req_base)));

  // R2
  indirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mode == 3'd1) |=> (rsp_addr == $past(req_base)));
endmodule

// File: tb/test_lsagu_top.sv
module test_lsagu_top;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [2:0]    req_mode = '0;
  logic          req_sub = 1'b0;
  logic [1:0]    req_shift = '0;
  logic [AW-1:0] req_base = '0, req_pc = '0, req_index = '0, req_imm = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [AW-1:0] rsp_addr, rsp_wb_val;
  logic          rsp_wb_en;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  lsagu_top #(.ADDR_W(AW), .SHIFT_W(2)) i_lsagu_top (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_sub(req_sub), .req_shift(req_shift),
    .req_base(req_base), .req_pc(req_pc), .req_index(req_index), .req_imm(req_imm),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_addr(rsp_addr), .rsp_wb_en(rsp_wb_en), .rsp_wb_val(rsp_wb_val)
  );

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string mode_tag(input int m);
    case (m)
      0: return "R1 abs";
      1: return "R2 ind";
      2: return "R3 ofs";
      3: return "R4 idx";
      4: return "R5 sidx";
      5: return "R6 pre";
      6: return "R7 post";
      default: return "R8 pcrel";
    endcase
  endfunction

  task automatic set_pattern(input int p);
    case (p)
      0: begin req_base = 32'h0000_1000; req_pc = 32'h0000_8000; req_index = 32'h3;          req_imm = 32'h8; end
      1: begin req_base = 32'hFFFF_FFF0; req_pc = 32'hFFFF_FFFC; req_index = 32'h5;          req_imm = 32'h20; end
      2: begin req_base = 32'h0000_0004; req_pc = 32'h0000_0000; req_index = 32'h4000_0001;  req_imm = 32'h10; end
      default: begin req_base = 32'h1234_5678; req_pc = 32'h0000_0100; req_index = 32'h8000_0000; req_imm = 32'hFFFF_FFFF; end
    endcase
  endtask

  // Expected values from the requirement text; 64-bit math then truncated (R10).
  task automatic expect_vals(output logic [AW-1:0] ea, output logic [AW-1:0] wen,
                             output logic [AW-1:0] wbv);
    longint signed dir = req_sub ? -1 : 1;
    longint unsigned b = req_base, pcv = req_pc, ix = req_index, im = req_imm;
    logic [AW-1:0] off_sum = AW'(b + dir * im);
    ea = '0; wen = '0; wbv = req_base;
    case (req_mode)
      3'd0: ea = req_imm;
      3'd1: ea = req_base;
      3'd2: ea = off_sum;
      3'd3: ea = AW'(b + dir * ix);
      3'd4: ea = AW'(b + dir * AW'(ix * (64'd1 << req_shift)));
      3'd5: begin ea = off_sum; wen = 1; wbv = off_sum; end
      3'd6: begin ea = req_base; wen = 1; wbv = off_sum; end
      default: ea = AW'(pcv + dir * im);
    endcase
  endtask

  initial begin
    logic [AW-1:0] e_ea, e_wen, e_wbv;
    logic [AW-1:0] hold_ea, hold_wbv;
    // R13: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R13 rsp_valid in reset", AW'(rsp_valid), 0);
    chk("R13 req_ready in reset", AW'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 rsp_valid after reset", AW'(rsp_valid), 0);

    // Full sweep: mode x direction x shift x operand pattern.
    for (int m = 0; m < 8; m++)
      for (int s = 0; s < 2; s++)
        for (int sh = 0; sh < 4; sh++)
          for (int p = 0; p < 4; p++) begin
            req_mode = 3'(m); req_sub = s[0]; req_shift = 2'(sh);
            set_pattern(p);
            req_valid = 1'b1;
            expect_vals(e_ea, e_wen, e_wbv);
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            // R11: response one edge after acceptance
            chk("R11 rsp_valid", AW'(rsp_valid), 1);
            chk({mode_tag(m), " addr (R10 wrap)"}, rsp_addr, e_ea);
            chk((m == 5 || m == 6) ? {mode_tag(m), " wb_en"} : "R9 wb_en", AW'(rsp_wb_en), e_wen);
            chk((m == 5 || m == 6) ? {mode_tag(m), " wb_val"} : "R9 wb_val", rsp_wb_val, e_wbv);
          end

    @(negedge clk);
    chk("R11 rsp_valid drops when idle", AW'(rsp_valid), 0);

    // R12: back-pressure with a second request waiting.
    rsp_ready = 1'b0;
    req_mode = 3'd5; req_sub = 1'b0; set_pattern(0);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    hold_ea = rsp_addr; hold_wbv = rsp_wb_val;
    chk("R12 first response addr", hold_ea, 32'h0000_1008);
    req_mode = 3'd6; req_sub = 1'b1; set_pattern(1);
    chk("R12 req_ready low while stalled", AW'(req_ready), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R12 held addr", rsp_addr, hold_ea);
    chk("R12 held wb_val", rsp_wb_val, hold_wbv);
    chk("R12 held wb_en", AW'(rsp_wb_en), 1);
    chk("R12 still refusing", AW'(req_ready), 0);
    rsp_ready = 1'b1;
    #1;
    chk("R12 ready when draining", AW'(req_ready), 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 queued post addr", rsp_addr, 32'hFFFF_FFF0);
    chk("R7 queued post wb_val", rsp_wb_val, 32'hFFFF_FFD0);
    @(negedge clk);
    chk("R12 empty after drain", AW'(rsp_valid), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule